// File: doc/BRIEF.md
# Oversampled SPI Slave Port

This block is a serial slave port for a system-clocked chip. An external master drives a serial clock and an active-low slave-select. Both are asynchronous to the system clock. The port brings both into the system domain through a two-flop synchronizer. It then looks at them on an internal sample tick that fires on every second system clock. Every protocol decision is taken on these re-timed copies. The serial data input goes through the same synchronizer, so it stays aligned with the clock it belongs to. Receive and transmit share the one external clock and the one select line.

A word starts only on a falling edge of the select line. There is no bit gap: the most significant transmit bit is already on the data output when the select falls. The port captures received bits on rising serial-clock edges and advances transmit bits on falling edges. When the set number of bits has arrived, it presents the received word with a one-cycle valid strobe. After that it ignores the serial clock until the select rises. If the select rises before the word is complete, the port drops the partial word, pulses an abort strobe and returns to idle. Word length can be set from 8 to 32 bits. The master runs at up to a quarter of the system clock and must release the select after every word.

Top module: `ovs_spi_slave`

## Requirements
- R1: Words are captured and sent correctly when the serial clock runs at one quarter of the system clock, with two system cycles high and two low.
- R2: A transfer begins only on a falling edge of `ssel_n`. While `ssel_n` stays low after a completed word, further serial clocks give no `rx_valid` and no `rx_abort`.
- R3: Data delay is zero. The first bit seen on `miso` after `ssel_n` falls is the most significant of the configured word length.
- R4: Received bits are shifted in MSB first. `rx_word` holds the word right-justified, and all bits at or above the effective length read 0.
- R5: `rx_valid` is high for exactly one system cycle for each completed word, after the last rising edge of the serial clock.
- R6: `miso` presents the low word-length bits of the pending transmit word, MSB first, and advances one bit on each falling edge of the serial clock.
- R7: `word_len` values below 8 act as 8, and values above 32 act as 32.
- R8: If `ssel_n` rises before a full word has arrived, `rx_abort` pulses for one cycle, `rx_valid` stays low, and the next word is received normally.
- R9: `miso_oe` is 0 while the port is idle (select inactive) and 1 during a transfer.
- R10: A pulse on `tx_load` captures `tx_word`. The value captured most recently before `ssel_n` falls is the one sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk | input | 1 | Serial clock from the master, asynchronous |
| ssel_n | input | 1 | Active-low slave select from the master, asynchronous |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the `miso` pad driver |
| word_len | input | 6 | Bits per word, clamped to 8..32 |
| tx_word | input | 32 | Transmit word, right-justified |
| tx_load | input | 1 | Captures `tx_word` as the pending transmit word |
| rx_word | output | 32 | Last received word, right-justified |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` is updated |
| rx_abort | output | 1 | One-cycle strobe when a partial word is dropped |

## Verification
A change on a serial input takes effect 2.5 to 3.5 system cycles later. That covers half a cycle to the first synchronizer flop, one more to the second, and up to one cycle waiting for a sample tick before the state register updates. The bench therefore changes `sclk` only on falling system-clock edges and reads `miso` just before it drives the next falling serial edge. That read comes four cycles after the previous falling serial edge, which is half a cycle after the latest time `miso` can move. Strobes are counted on every falling system-clock edge by a monitor. The counts are compared after a settling gap of several cycles that follows each release of the select.

// File: rtl/ovs_spi_pkg.sv
package ovs_spi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/ovs_spi_sync.sv
module ovs_spi_sync #(
  parameter int              W       = 3,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[g];
        stab_q <= RST_VAL[g];
      end else begin
        meta_q <= d_async[g];
        stab_q <= meta_q;
      end
    end
    assign q_sync[g] = stab_q;
  end
endmodule

// File: rtl/ovs_spi_sampler.sv
module ovs_spi_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic ssel_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic ssel_fall,
  output logic ssel_rise
);
  logic tick_q, tick_d;
  logic sclk_p_q, sclk_p_d;
  logic ssel_p_q, ssel_p_d;

  always_comb begin
    tick_d   = ~tick_q;
    sclk_p_d = sclk_p_q;
    ssel_p_d = ssel_p_q;
    if (tick_q) begin
      sclk_p_d = sclk_s;
      ssel_p_d = ssel_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q   <= 1'b0;
      sclk_p_q <= 1'b0;
      ssel_p_q <= 1'b1;
    end else begin
      tick_q   <= tick_d;
      sclk_p_q <= sclk_p_d;
      ssel_p_q <= ssel_p_d;
    end
  end

  assign sclk_rise = tick_q &  sclk_s & ~sclk_p_q;
  assign sclk_fall = tick_q & ~sclk_s &  sclk_p_q;
  assign ssel_fall = tick_q & ~ssel_s &  ssel_p_q;
  assign ssel_rise = tick_q &  ssel_s & ~ssel_p_q;

  // R1: the sample tick runs at half the system rate
  a_r1_tick_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);
  a_r1_tick_resumes: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_q |=> tick_q);
endmodule

// File: rtl/ovs_spi_engine.sv
module ovs_spi_engine
  import ovs_spi_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int LEN_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LEN_W-1:0]    eff_len,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic                tx_load,
  input  logic                mosi_s,
  input  logic                sclk_rise,
  input  logic                sclk_fall,
  input  logic                ssel_fall,
  input  logic                ssel_rise,
  output logic                miso,
  output logic                miso_oe,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                rx_valid,
  output logic                rx_abort
);
  function automatic logic [MAX_BITS-1:0] left_align(input logic [MAX_BITS-1:0] v,
                                                     input logic [LEN_W-1:0] n);
    return v << (MAX_BITS - int'(n));
  endfunction

  function automatic logic [MAX_BITS-1:0] len_mask(input logic [LEN_W-1:0] n);
    logic [MAX_BITS-1:0] m;
    for (int i = 0; i < MAX_BITS; i++) m[i] = (i < int'(n));
    return m;
  endfunction

  xfer_state_e         state_q, state_d;
  logic [MAX_BITS-1:0] hold_q, hold_d;
  logic [MAX_BITS-1:0] txsh_q, txsh_d;
  logic [MAX_BITS-1:0] rxsh_q, rxsh_d;
  logic [LEN_W-1:0]    cnt_q, cnt_d;
  logic [MAX_BITS-1:0] rxw_q, rxw_d;
  logic                val_q, val_d;
  logic                abt_q, abt_d;
  logic [MAX_BITS-1:0] rx_shifted;
  logic [LEN_W-1:0]    cnt_inc;

  assign rx_shifted = {rxsh_q[MAX_BITS-2:0], mosi_s};
  assign cnt_inc    = cnt_q + 1'b1;

  always_comb begin
    state_d = state_q;
    hold_d  = hold_q;
    txsh_d  = txsh_q;
    rxsh_d  = rxsh_q;
    cnt_d   = cnt_q;
    rxw_d   = rxw_q;
    val_d   = 1'b0;
    abt_d   = 1'b0;
    if (tx_load) hold_d = tx_word;
    unique case (state_q)
      ST_IDLE: begin
        if (ssel_fall) begin
          state_d = ST_SHIFT;
          txsh_d  = left_align(hold_q, eff_len);
          rxsh_d  = '0;
          cnt_d   = '0;
        end
      end
      ST_SHIFT: begin
        if (ssel_rise) begin
          state_d = ST_IDLE;
          abt_d   = 1'b1;
        end else if (sclk_rise) begin
          rxsh_d = rx_shifted;
          cnt_d  = cnt_inc;
          if (cnt_inc == eff_len) begin
            rxw_d   = rx_shifted & len_mask(eff_len);
            val_d   = 1'b1;
            state_d = ST_HOLD;
          end
        end else if (sclk_fall) begin
          txsh_d = txsh_q << 1;
        end
      end
      ST_HOLD: begin
        if (ssel_rise) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
      txsh_q  <= '0;
      rxsh_q  <= '0;
      cnt_q   <= '0;
      rxw_q   <= '0;
      val_q   <= 1'b0;
      abt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
      txsh_q  <= txsh_d;
      rxsh_q  <= rxsh_d;
      cnt_q   <= cnt_d;
      rxw_q   <= rxw_d;
      val_q   <= val_d;
      abt_q   <= abt_d;
    end
  end

  logic [MAX_BITS-1:0] idle_aligned;
  assign idle_aligned = left_align(hold_q, eff_len);
  assign miso     = (state_q == ST_IDLE) ? idle_aligned[MAX_BITS-1] : txsh_q[MAX_BITS-1];
  assign miso_oe  = (state_q != ST_IDLE);
  assign rx_word  = rxw_q;
  assign rx_valid = val_q;
  assign rx_abort = abt_q;

  // R5: one strobe per word
  a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    val_q |=> !val_q);
  // R8: a dropped word never also reports valid
  a_r8_abort_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(val_q && abt_q));
  a_r8_abort_on_early_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT && ssel_rise) |=> abt_q);
  // R2: leaving idle needs a select falling edge
  a_r2_start_needs_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !ssel_fall) |=> state_q == ST_IDLE);
  // R2: a held word ignores serial clocks
  a_r2_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |=> !val_q && !abt_q);
  // R4: bits above the length read zero
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    val_q |-> ((rxw_q & ~len_mask(eff_len)) == '0));
endmodule

// File: rtl/ovs_spi_slave.sv
module ovs_spi_slave #(
  parameter int MAX_BITS = 32,
  parameter int MIN_BITS = 8,
  localparam int LEN_W   = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                ssel_n,
  input  logic                mosi,
  output logic                miso,
  output logic                miso_oe,
  input  logic [LEN_W-1:0]    word_len,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic                tx_load,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                rx_valid,
  output logic                rx_abort
);
  logic rst_a_q, rst_b_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q <= 1'b0;
      rst_b_q <= 1'b0;
    end else begin
      rst_a_q <= 1'b1;
      rst_b_q <= rst_a_q;
    end
  end

  logic [2:0] pins_s;
  ovs_spi_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk     (clk),
    .rst_n   (rst_b_q),
    .d_async ({mosi, ssel_n, sclk}),
    .q_sync  (pins_s)
  );

  logic sclk_rise, sclk_fall, ssel_fall, ssel_rise;
  ovs_spi_sampler u_samp (
    .clk       (clk),
    .rst_n     (rst_b_q),
    .sclk_s    (pins_s[0]),
    .ssel_s    (pins_s[1]),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .ssel_fall (ssel_fall),
    .ssel_rise (ssel_rise)
  );

  logic [LEN_W-1:0] eff_len;
  always_comb begin
    if (word_len < LEN_W'(MIN_BITS))      eff_len = LEN_W'(MIN_BITS);
    else if (word_len > LEN_W'(MAX_BITS)) eff_len = LEN_W'(MAX_BITS);
    else                                  eff_len = word_len;
  end

  ovs_spi_engine #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_b_q),
    .eff_len   (eff_len),
    .tx_word   (tx_word),
    .tx_load   (tx_load),
    .mosi_s    (pins_s[2]),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .ssel_fall (ssel_fall),
    .ssel_rise (ssel_rise),
    .miso      (miso),
    .miso_oe   (miso_oe),
    .rx_word   (rx_word),
    .rx_valid  (rx_valid),
    .rx_abort  (rx_abort)
  );

  // R9: output enable never rises while the select is inactive in sync
  a_r9_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_b_q)
    $rose(miso_oe) |-> !pins_s[1]);
endmodule

// File: tb/ovs_spi_slave_test.sv
module ovs_spi_slave_test;
  logic        clk, rst_n, sclk, ssel_n, mosi, miso, miso_oe, tx_load;
  logic [5:0]  word_len;
  logic [31:0] tx_word, rx_word;
  logic        rx_valid, rx_abort;

  int n_checks = 0, n_fail = 0;
  int n_valid = 0, n_abort = 0;
  logic [31:0] last_rx;
  logic        oe_seen;

  ovs_spi_slave uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .ssel_n(ssel_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .word_len(word_len), .tx_word(tx_word),
    .tx_load(tx_load), .rx_word(rx_word), .rx_valid(rx_valid), .rx_abort(rx_abort)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rx_valid) begin n_valid++; last_rx = rx_word; end
    if (rx_abort) n_abort++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_tx(input logic [31:0] v);
    @(negedge clk) tx_word = v; tx_load = 1'b1;
    @(negedge clk) tx_load = 1'b0; tx_word = 32'h0;
  endtask

  // master side: nb bits of mdata (len-bit word, MSB first), extra clocks with select held
  task automatic xfer(input int nb, input int len, input logic [31:0] mdata,
                      input int extra, output logic [31:0] got);
    got = '0;
    oe_seen = 1'b0;
    @(negedge clk) ssel_n = 1'b0;
    repeat (4) @(negedge clk);
    oe_seen = miso_oe;
    for (int i = 0; i < nb; i++) begin
      mosi = mdata[len-1-i];
      sclk = 1'b0;
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      repeat (2) @(negedge clk);
      got = {got[30:0], miso};
    end
    for (int j = 0; j < extra; j++) begin
      sclk = 1'b0; repeat (2) @(negedge clk);
      sclk = 1'b1; repeat (2) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    ssel_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(rx_valid == 1'b0, "R5 reset valid", {31'b0, rx_valid}, 0);
    chk(miso_oe == 1'b0, "R9 reset oe", {31'b0, miso_oe}, 0);
    chk(rx_word == 32'h0, "R4 reset word", rx_word, 0);
  endtask

  task automatic t_word(input string tag, input int len, input logic [31:0] txv,
                        input logic [31:0] mv);
    logic [31:0] got, m;
    int v0, a0;
    m = (len == 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
    word_len = 6'(len);
    load_tx(32'h5555_5555);
    load_tx(txv);                                   // R10: last load wins
    v0 = n_valid; a0 = n_abort;
    xfer(len, len, mv, 0, got);
    chk(n_valid == v0 + 1, {tag, " R5 one valid"}, n_valid - v0, 1);
    chk(n_abort == a0, {tag, " R8 no abort"}, n_abort - a0, 0);
    chk(last_rx == (mv & m), {tag, " R4 R1 rx word"}, last_rx, mv & m);
    chk(got == (txv & m), {tag, " R3 R6 R10 miso bits"}, got, txv & m);
    chk(oe_seen == 1'b1, {tag, " R9 oe active"}, {31'b0, oe_seen}, 1);
    chk(miso_oe == 1'b0, {tag, " R9 oe idle"}, {31'b0, miso_oe}, 0);
  endtask

  task automatic t_clamp;
    logic [31:0] got;
    int v0;
    word_len = 6'd3;                                // R7 acts as 8
    load_tx(32'h0000_00C3);
    v0 = n_valid;
    xfer(8, 8, 32'h0000_0096, 0, got);
    chk(n_valid == v0 + 1 && last_rx == 32'h96, "R7 low clamp rx", last_rx, 32'h96);
    chk(got == 32'hC3, "R7 low clamp miso", got, 32'hC3);
    word_len = 6'd45;                               // R7 acts as 32
    load_tx(32'h8765_4321);
    v0 = n_valid;
    xfer(32, 32, 32'hF0E1_D2C3, 0, got);
    chk(n_valid == v0 + 1 && last_rx == 32'hF0E1_D2C3, "R7 high clamp rx", last_rx, 32'hF0E1_D2C3);
    chk(got == 32'h8765_4321, "R7 high clamp miso", got, 32'h8765_4321);
  endtask

  task automatic t_abort;
    logic [31:0] got, prev;
    int v0, a0;
    word_len = 6'd16;
    prev = last_rx;
    v0 = n_valid; a0 = n_abort;
    xfer(5, 16, 32'h0000_FFFF, 0, got);
    chk(n_abort == a0 + 1, "R8 abort pulse", n_abort - a0, 1);
    chk(n_valid == v0, "R8 no valid", n_valid - v0, 0);
    chk(rx_word == prev, "R8 word kept", rx_word, prev);
    t_word("after abort", 16, 32'h0000_A1B2, 32'h0000_7E81);
  endtask

  task automatic t_held;
    logic [31:0] got;
    int v0, a0;
    word_len = 6'd8;
    load_tx(32'h0000_005A);
    v0 = n_valid; a0 = n_abort;
    xfer(8, 8, 32'h0000_00E7, 10, got);             // R2 extra clocks while held
    chk(n_valid == v0 + 1, "R2 held one valid", n_valid - v0, 1);
    chk(n_abort == a0, "R2 held no abort", n_abort - a0, 0);
    chk(last_rx == 32'hE7, "R2 held rx", last_rx, 32'hE7);
    t_word("fresh edge", 8, 32'h0000_0011, 32'h0000_0080);
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; ssel_n = 1'b1; mosi = 1'b0;
    tx_load = 1'b0; tx_word = '0; word_len = 6'd8;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_word("len8", 8, 32'h0000_00A5, 32'h0000_003C);
    t_word("len16", 16, 32'h0000_BEEF, 32'h0000_1234);
    t_word("len32", 32, 32'hDEAD_BEEF, 32'hC001_D00D);
    t_word("len8 after32", 8, 32'hFFFF_FF81, 32'hFFFF_FF7F);
    t_word("len13", 13, 32'h0000_1ACE, 32'h0000_0F0F);
    t_clamp();
    t_abort();
    t_held();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule